// File: doc/BRIEF.md
# Workgroup Barrier Arrival Counter

This unit synchronises the waves of one thread group at a barrier. When a wave reaches the barrier it pulses its own `arrive` line. From then on the unit holds that wave stalled. For each accepted arrival the unit adds the wave's thread quantum to a shared tally. The quantum is 32 or 64 threads, chosen by a configuration input. The group size is a separate input.

When the tally lands exactly on the configured group size, the unit does three things together:
- it broadcasts a one-cycle release pulse to every wave;
- it drops all stalls;
- it empties the tally, so the next barrier can start in the very next cycle.

If some threads never arrive, for example because they took a divergent branch, the tally never reaches the group size. The arrived waves then stay stalled, and nothing inside the unit recovers them. To expose this, a programmable watchdog raises a `hang` flag once the tally has been non-empty but short of release for too long. A wave that pulses `arrive` again while it is already stalled is reported on its error line and is not counted twice.

Top module: `wg_barrier_sync`

## Requirements
- R1: While and right after reset, `release_pulse`, `stall`, `dup_err` and `hang` are low and `arrived_threads` is 0.
- R2: Each accepted arrival adds 32 threads to `arrived_threads` when `cfg_wave64`=0, or 64 when `cfg_wave64`=1. Arrivals from several waves in the same cycle add up. The new total is visible one cycle after the arrival.
- R3: If the arrivals of a cycle bring the tally to exactly `cfg_group_size`, then in the next cycle three things hold: `release_pulse` is high for that one cycle, `arrived_threads` is 0, and all `stall` bits are low.
- R4: No release occurs while the tally is below `cfg_group_size` or has passed it. An overshooting barrier stays stalled until reset.
- R5: Bit i of `stall` goes high one cycle after wave i (bit i of `arrive`) is accepted. It stays high until the release.
- R6: An `arrive` from a wave whose `stall` bit is already high is not counted. It raises that wave's `dup_err` bit for exactly the next cycle.
- R7: Arrivals made during a release cycle count toward the next barrier. If they complete it, a second release follows on the very next cycle.
- R8: With `cfg_hang_limit`=T (T>0), `hang` rises T cycles after the tally first became non-zero, if no release occurs first. It stays high until a release or reset. T=0 disables `hang`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wave64 | input | 1 | 0: 32 threads per wave, 1: 64 threads per wave |
| cfg_group_size | input | CNT_W | Thread count that completes the barrier |
| cfg_hang_limit | input | TMO_W | Cycles before `hang` rises; 0 disables it |
| arrive | input | NUM_WAVES | One-cycle arrival pulse per wave |
| release_pulse | output | 1 | One-cycle release broadcast |
| stall | output | NUM_WAVES | Wave is held at the barrier |
| dup_err | output | NUM_WAVES | Repeated arrival before release, one cycle |
| arrived_threads | output | CNT_W | Current barrier tally |
| hang | output | 1 | Barrier partly filled for too long |

## Verification
The hardest states to reach are an exact release in the cycle straight after another release, and a barrier that overshoots its group size and so can never complete.

- **Back-to-back release.** The stimulus makes every wave arrive in the same cycle that carries the previous release pulse.
- **Overshoot.** The stimulus selects 64-thread waves against a group size of 96, so the second arrival jumps past the target.

In the overshoot case the bench then waits out the watchdog and counts the exact cycle in which `hang` rises. After that, only a reset clears the stuck waves.

// File: rtl/wgb_pkg.sv
package wgb_pkg;
  localparam int unsigned NARROW_THREADS = 32;
  localparam int unsigned WIDE_THREADS   = 64;

  // threads carried by one accepted arrival
  function automatic int unsigned wave_quantum(input logic wide);
    return wide ? WIDE_THREADS : NARROW_THREADS;
  endfunction

  // threads added by a given number of simultaneous arrivals
  function automatic int unsigned batch_threads(input int unsigned waves, input logic wide);
    return waves * wave_quantum(wide);
  endfunction
endpackage

// File: rtl/wgb_arrival_tracker.sv
module wgb_arrival_tracker #(
  parameter int NUM_WAVES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WAVES-1:0] arrive,
  input  logic                 done,
  output logic [NUM_WAVES-1:0] accepted,
  output logic [NUM_WAVES-1:0] pending_q,
  output logic [NUM_WAVES-1:0] dup_q
);
  logic [NUM_WAVES-1:0] repeat_hit;

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    assign accepted[w]   = arrive[w] & ~pending_q[w];
    assign repeat_hit[w] = arrive[w] &  pending_q[w];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending_q[w] <= 1'b0;
        dup_q[w]     <= 1'b0;
      end else begin
        pending_q[w] <= done ? 1'b0 : (pending_q[w] | accepted[w]);
        dup_q[w]     <= repeat_hit[w];
      end
    end
  end
endmodule

// File: rtl/wgb_thread_counter.sv
module wgb_thread_counter
  import wgb_pkg::*;
#(
  parameter int NUM_WAVES = 4,
  parameter int CNT_W     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WAVES-1:0] accepted,
  input  logic                 wave64,
  input  logic [CNT_W-1:0]     group_size,
  output logic [CNT_W-1:0]     count_q,
  output logic                 done,
  output logic                 release_q
);
  logic [CNT_W-1:0] add_threads;
  logic [CNT_W-1:0] next_count;

  always_comb begin
    int unsigned n;
    n = 0;
    for (int w = 0; w < NUM_WAVES; w++) n += int'(accepted[w]);
    add_threads = CNT_W'(batch_threads(n, wave64));
    next_count  = count_q + add_threads;
    done        = (next_count == group_size) && (next_count != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      release_q <= 1'b0;
    end else begin
      count_q   <= done ? '0 : next_count;
      release_q <= done;
    end
  end
endmodule

// File: rtl/wgb_hang_timer.sv
module wgb_hang_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             done,
  input  logic [TMO_W-1:0] limit,
  output logic             hang
);
  localparam logic [TMO_W-1:0] SAT = '1;
  logic [TMO_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wait_q <= '0;
    else if (!busy || done) wait_q <= '0;
    else if (wait_q != SAT) wait_q <= wait_q + 1'b1;
  end

  assign hang = busy && (limit != '0) && (wait_q >= limit);
endmodule

// File: rtl/wg_barrier_sync.sv
module wg_barrier_sync #(
  parameter int NUM_WAVES = 4,
  parameter int TMO_W     = 16,
  localparam int CNT_W    = $clog2(NUM_WAVES * wgb_pkg::WIDE_THREADS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wave64,
  input  logic [CNT_W-1:0]     cfg_group_size,
  input  logic [TMO_W-1:0]     cfg_hang_limit,
  input  logic [NUM_WAVES-1:0] arrive,
  output logic                 release_pulse,
  output logic [NUM_WAVES-1:0] stall,
  output logic [NUM_WAVES-1:0] dup_err,
  output logic [CNT_W-1:0]     arrived_threads,
  output logic                 hang
);
  // named internal events, also observed by the checker
  logic                 done_evt;
  logic [NUM_WAVES-1:0] accepted;
  logic                 busy;

  wgb_arrival_tracker #(.NUM_WAVES(NUM_WAVES)) u_track (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .done(done_evt),
    .accepted(accepted), .pending_q(stall), .dup_q(dup_err)
  );

  wgb_thread_counter #(.NUM_WAVES(NUM_WAVES), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .accepted(accepted), .wave64(cfg_wave64),
    .group_size(cfg_group_size), .count_q(arrived_threads),
    .done(done_evt), .release_q(release_pulse)
  );

  assign busy = (arrived_threads != '0);

  wgb_hang_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_evt),
    .limit(cfg_hang_limit), .hang(hang)
  );
endmodule

// File: rtl/wgb_checker.sv
module wgb_checker #(
  parameter int NUM_WAVES = 4,
  parameter int CNT_W     = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 release_pulse,
  input logic [NUM_WAVES-1:0] stall,
  input logic [NUM_WAVES-1:0] dup_err,
  input logic [CNT_W-1:0]     arrived_threads,
  input logic                 hang,
  input logic                 done_evt
);
  p_clear_on_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> (arrived_threads == '0 && stall == '0));

  p_done_to_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> release_pulse);

  p_tally_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !release_pulse |-> (arrived_threads >= $past(arrived_threads)));

  p_stall_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stall & $past(stall)) != '0) |-> release_pulse);

  p_dup_only_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dup_err & ~$past(stall)) == '0));

  p_hang_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hang |-> (arrived_threads != '0 && !release_pulse));
endmodule

bind wg_barrier_sync wgb_checker #(.NUM_WAVES(NUM_WAVES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .release_pulse(release_pulse), .stall(stall),
  .dup_err(dup_err), .arrived_threads(arrived_threads), .hang(hang),
  .done_evt(done_evt)
);

// File: tb/wg_barrier_sync_tb.sv
module wg_barrier_sync_tb;
  localparam int NW = 4;
  localparam int CW = 9;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wave64 = 1'b0;
  logic [CW-1:0] cfg_group_size = 9'd128;
  logic [TW-1:0] cfg_hang_limit = '0;
  logic [NW-1:0] arrive = '0;
  logic          release_pulse;
  logic [NW-1:0] stall;
  logic [NW-1:0] dup_err;
  logic [CW-1:0] arrived_threads;
  logic          hang;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wg_barrier_sync #(.NUM_WAVES(NW), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wave64(cfg_wave64),
    .cfg_group_size(cfg_group_size), .cfg_hang_limit(cfg_hang_limit),
    .arrive(arrive), .release_pulse(release_pulse), .stall(stall),
    .dup_err(dup_err), .arrived_threads(arrived_threads), .hang(hang)
  );

  // vector: arrive(4) exp_release(1) exp_count(9) exp_stall(4) exp_err(4)
  // 32-thread waves, group size 128
  localparam int NVEC = 10;
  localparam logic [21:0] VEC [NVEC] = '{
    {4'b0001, 1'b0, 9'd32,  4'b0001, 4'b0000},  // R2 first wave
    {4'b0010, 1'b0, 9'd64,  4'b0011, 4'b0000},  // R5 stall builds
    {4'b0001, 1'b0, 9'd64,  4'b0011, 4'b0001},  // R6 repeat not counted
    {4'b1100, 1'b1, 9'd0,   4'b0000, 4'b0000},  // R3 exact fill
    {4'b1111, 1'b1, 9'd0,   4'b0000, 4'b0000},  // R7 back to back
    {4'b0000, 1'b0, 9'd0,   4'b0000, 4'b0000},  // R3 single pulse
    {4'b0101, 1'b0, 9'd64,  4'b0101, 4'b0000},  // R2 two at once
    {4'b0000, 1'b0, 9'd64,  4'b0101, 4'b0000},  // R4 partial holds
    {4'b1010, 1'b1, 9'd0,   4'b0000, 4'b0000},  // R3 fill
    {4'b0000, 1'b0, 9'd0,   4'b0000, 4'b0000}   // R1 idle
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive arrive at negedge, sample 1ns after the following rising edge
  task automatic step(input logic [NW-1:0] a);
    @(negedge clk);
    arrive = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    arrive = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 release", int'(release_pulse), 0);
    check("R1 count", int'(arrived_threads), 0);
    check("R1 stall", int'(stall), 0);
    check("R1 hang", int'(hang), 0);
    do_reset();

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][21:18]);
      check("R3 release", int'(release_pulse), int'(VEC[k][17]));
      check("R2 count", int'(arrived_threads), int'(VEC[k][16:8]));
      check("R5 stall", int'(stall), int'(VEC[k][7:4]));
      check("R6 dup_err", int'(dup_err), int'(VEC[k][3:0]));
    end
    step('0);
    check("R6 dup_err one cycle", int'(dup_err), 0);

    // R2: 64-thread waves
    cfg_wave64 = 1'b1;
    cfg_group_size = 9'd128;
    step(4'b0001);
    check("R2 wide count", int'(arrived_threads), 64);
    check("R2 wide no release", int'(release_pulse), 0);
    step(4'b0100);
    check("R2 wide release", int'(release_pulse), 1);
    check("R3 wide cleared", int'(arrived_threads), 0);

    // R4 and R8: overshoot 96 with 64-thread waves, limit 5
    cfg_group_size = 9'd96;
    cfg_hang_limit = 16'd5;
    do_reset();
    step(4'b0001);
    check("R2 overshoot first", int'(arrived_threads), 64);
    for (int k = 1; k <= 4; k++) begin
      step('0);
      check("R8 hang early", int'(hang), 0);
    end
    step('0);
    check("R8 hang at limit", int'(hang), 1);
    step(4'b0010);
    check("R4 overshoot no release", int'(release_pulse), 0);
    check("R4 overshoot count", int'(arrived_threads), 128);
    check("R4 overshoot stall", int'(stall), 3);
    for (int k = 0; k < 6; k++) step('0);
    check("R4 stays stuck", int'(stall), 3);
    check("R8 hang holds", int'(hang), 1);
    do_reset();
    #1;
    check("R1 reset recovers stall", int'(stall), 0);
    check("R1 reset clears hang", int'(hang), 0);

    // R8: limit 0 disables
    cfg_wave64 = 1'b0;
    cfg_group_size = 9'd64;
    cfg_hang_limit = 16'd0;
    step(4'b0001);
    for (int k = 0; k < 8; k++) step('0);
    check("R8 disabled", int'(hang), 0);
    do_reset();

    // R8: hang clears on release
    cfg_hang_limit = 16'd3;
    step(4'b0001);
    for (int k = 0; k < 3; k++) step('0);
    check("R8 hang limit 3", int'(hang), 1);
    step(4'b0010);
    check("R8 release", int'(release_pulse), 1);
    check("R8 hang cleared", int'(hang), 0);
    step('0);
    check("R3 pulse ends", int'(release_pulse), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule